// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block turns a fast reference clock into the 16x oversampling reference that a UART serial port uses. Software loads a 16-bit divisor as two byte-wide halves. The block counts that many reference cycles for each output period. It produces two outputs: the level of the divided clock, and a single-cycle tick on the last cycle of every period. The UART logic runs on the reference clock and uses the tick as its enable.

A write to either half restarts the period at once, so a new divisor takes effect without first running out a long old count. Three small divisors have their own output behaviour:

- Zero divides by three.
- One passes an inverted copy of the reference clock to a separate output. The tick fires on every cycle in this mode.
- Two gives a square wave at half the reference frequency.

From reset both halves hold zero, so the divider runs at divide-by-three until it is programmed.

Top module: `baud_rate_divider`

## Requirements
- R1: While reset is active and on the first cycle after it, the divisor is 0. The level output is low and the tick output is low.
- R2: `latch_we` bit 0 loads `latch_wdata` into divisor bits 7:0, and bit 1 loads it into bits 15:8. A write to one half leaves the other half unchanged, so divisors up to 65535 give periods of that many cycles.
- R3: In the cycle after any write, the divider is at the first cycle of a new period. The level is low there unless the new divisor is 1.
- R4: A divisor N of 3 or more gives a period of N cycles. The level is low for the first 2 cycles and high for the remaining N-2. The tick is high only on the last cycle.
- R5: A divisor of 0 gives a period of 3 cycles: level low, low, high. The tick is high on the third cycle.
- R6: A divisor of 2 makes the level alternate low and high on successive cycles. The tick is high on each high cycle.
- R7: A divisor of 1 holds the level high and the tick high on every cycle. `baud_clk_n` is the inverse of `clk`.
- R8: With any divisor other than 1, `baud_clk_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_we | input | 2 | Write enables for the divisor halves: bit 0 low byte, bit 1 high byte |
| latch_wdata | input | 8 | Byte written to the enabled halves |
| baud_lvl | output | 1 | Level of the divided clock |
| baud_tick | output | 1 | High on the last cycle of each output period |
| baud_clk_n | output | 1 | Inverted reference clock while the divisor is 1, low otherwise |

## Verification
The assertions assume that `latch_we` and `latch_wdata` change only away from the rising clock edge. They also assume that writes are separated from one another by at least one idle cycle. Otherwise the restart checks would compare against a divisor that is still in flight. The bench drives every input two nanoseconds after the rising edge. It leaves each write enable high for exactly one cycle, and it runs several periods between writes. Writes are also placed in the middle of a period, to exercise the restart.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  typedef enum logic [1:0] {
    MODE_DIV3  = 2'd0,
    MODE_INV   = 2'd1,
    MODE_HALF  = 2'd2,
    MODE_PULSE = 2'd3
  } div_mode_e;

  // Number of reference cycles in one output period for a programmed value.
  function automatic int unsigned eff_count(input int unsigned div);
    return (div == 0) ? 32'd3 : div;
  endfunction

  function automatic div_mode_e mode_of(input int unsigned div);
    if (div == 0) return MODE_DIV3;
    if (div == 1) return MODE_INV;
    if (div == 2) return MODE_HALF;
    return MODE_PULSE;
  endfunction

  // Level while the down counter holds cnt (eff..1) for a period of eff cycles.
  function automatic logic shape_level(input int unsigned eff,
                                       input int unsigned cnt,
                                       input int unsigned low_span);
    if (eff == 1) return 1'b1;
    if (eff == 2) return (cnt == 1);
    return (cnt + low_span <= eff);
  endfunction

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch
  import baud_div_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int DIV_W    = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BYTES-1:0] we,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [DIV_W-1:0]     div_q,
  output logic [DIV_W-1:0]     div_next,
  output logic                 load
);

  logic [BYTE_W-1:0] lane_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q[g] <= '0;
      else if (we[g]) lane_q[g] <= wdata;
    end
    assign div_q[g*BYTE_W +: BYTE_W]    = lane_q[g];
    assign div_next[g*BYTE_W +: BYTE_W] = we[g] ? wdata : lane_q[g];
  end

  assign load = |we;

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
  import baud_div_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_next,
  output logic [DIV_W-1:0] cnt,
  output logic             terminal
);

  logic [DIV_W-1:0] reload_now;
  logic [DIV_W-1:0] reload_new;

  always_comb begin
    reload_now = DIV_W'(eff_count(32'(div_q)));
    reload_new = DIV_W'(eff_count(32'(div_next)));
  end

  assign terminal = (cnt == DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= DIV_W'(eff_count(32'd0));
    else if (load)     cnt <= reload_new;
    else if (terminal) cnt <= reload_now;
    else               cnt <= cnt - DIV_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (32'(cnt) <= eff_count(32'(div_q)))); // R4

endmodule

// File: rtl/baud_div_shaper.sv
module baud_div_shaper
  import baud_div_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int LOW_SPAN = 2
) (
  input  logic             clk,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] cnt,
  input  logic             terminal,
  output logic             lvl,
  output logic             tick,
  output logic             clk_n_out
);

  div_mode_e mode;

  always_comb begin
    mode = mode_of(32'(div_q));
    lvl  = shape_level(eff_count(32'(div_q)), 32'(cnt), LOW_SPAN);
    tick = terminal;
  end

  assign clk_n_out = (mode == MODE_INV) ? ~clk : 1'b0;

endmodule

// File: rtl/baud_rate_divider.sv
module baud_rate_divider
  import baud_div_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int LOW_SPAN  = 2,
  localparam int DIV_W    = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BYTES-1:0] latch_we,
  input  logic [BYTE_W-1:0]    latch_wdata,
  output logic                 baud_lvl,
  output logic                 baud_tick,
  output logic                 baud_clk_n
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             load;
  logic [DIV_W-1:0] cnt;
  logic             terminal;

  baud_div_latch #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) i_latch (
    .clk(clk), .rst_n(rst_n), .we(latch_we), .wdata(latch_wdata),
    .div_q(div_q), .div_next(div_next), .load(load)
  );

  baud_div_counter #(.DIV_W(DIV_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .load(load), .div_q(div_q),
    .div_next(div_next), .cnt(cnt), .terminal(terminal)
  );

  baud_div_shaper #(.DIV_W(DIV_W), .LOW_SPAN(LOW_SPAN)) i_shaper (
    .clk(clk), .div_q(div_q), .cnt(cnt), .terminal(terminal),
    .lvl(baud_lvl), .tick(baud_tick), .clk_n_out(baud_clk_n)
  );

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((div_q == DIV_W'(1)) || !baud_lvl)); // R3
  AST_TICK_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !load && (div_q != DIV_W'(1))) |=> !baud_lvl); // R4
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_q == DIV_W'(2)) && !load) |=> (baud_lvl != $past(baud_lvl))); // R6
  AST_DIV1_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_W'(1)) |-> (baud_tick && baud_lvl)); // R7
  AST_INV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != DIV_W'(1)) |-> !baud_clk_n); // R8

endmodule

// File: tb/test_baud_rate_divider.sv
module test_baud_rate_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] latch_we = 2'b00;
  logic [7:0] latch_wdata = 8'h00;
  logic       baud_lvl, baud_tick, baud_clk_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int m_div = 0;
  int m_phase = 0;
  bit m_written = 0;
  bit done = 0;

  always #5 clk = ~clk;

  baud_rate_divider i_baud_rate_divider (
    .clk(clk), .rst_n(rst_n), .latch_we(latch_we), .latch_wdata(latch_wdata),
    .baud_lvl(baud_lvl), .baud_tick(baud_tick), .baud_clk_n(baud_clk_n)
  );

  function automatic int period_of(input int d);
    if (d == 0) return 3;
    return d;
  endfunction

  // Reference model: advance one reference cycle per rising edge.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_div = 0; m_phase = 0; m_written = 0;
    end else if (latch_we != 2'b00) begin
      if (latch_we[0]) m_div = (m_div & 32'hFF00) | int'(latch_wdata);
      if (latch_we[1]) m_div = (m_div & 32'h00FF) | (int'(latch_wdata) << 8);
      m_phase = 0; m_written = 1;
    end else begin
      m_phase = (m_phase + 1) % period_of(m_div);
      m_written = 0;
    end
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check_bit(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b (div %0d phase %0d)", req, what, got, exp, m_div, m_phase);
    end
  endtask

  // Compare on every falling edge, away from the rising edge.
  always @(negedge clk) begin
    int e;
    logic x_lvl, x_tick, x_inv;
    string req;
    e = period_of(m_div);
    x_tick = (m_phase == e - 1);
    if (e == 1)      x_lvl = 1'b1;
    else if (e == 2) x_lvl = (m_phase == 1);
    else             x_lvl = (m_phase >= 2);
    x_inv = (m_div == 1);          // clk is low here, so its inverse is high
    if (!rst_n)           req = "R1";
    else if (m_written)   req = "R3";
    else if (m_div > 255) req = "R2";
    else if (m_div == 0)  req = "R5";
    else if (m_div == 1)  req = "R7";
    else if (m_div == 2)  req = "R6";
    else                  req = "R4";
    check_bit(req, "baud_lvl", baud_lvl, x_lvl);
    check_bit(req, "baud_tick", baud_tick, x_tick);
    check_bit((m_div == 1) ? "R7" : "R8", "baud_clk_n", baud_clk_n, x_inv);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic write(input logic [1:0] we, input logic [7:0] d);
    @(posedge clk); #2;
    latch_we = we; latch_wdata = d;
    @(posedge clk); #2;
    latch_we = 2'b00;
  endtask

  initial begin
    idle(3);
    #2 rst_n = 1'b1;
    idle(12);                    // R1 then R5: divide by three from reset
    write(2'b01, 8'd5);  idle(17);   // R4 period 5
    write(2'b01, 8'd3);  idle(11);   // R4 minimum pulse divisor
    write(2'b01, 8'd2);  idle(9);    // R6
    write(2'b01, 8'd1);  idle(6);    // R7
    write(2'b01, 8'd0);  idle(7);    // R5 programmed zero
    write(2'b01, 8'd9);  idle(4);
    write(2'b01, 8'd7);  idle(20);   // R3 mid-period restart
    write(2'b10, 8'd1);  idle(800);  // R2 high byte keeps low byte: 263
    write(2'b01, 8'd4);  idle(600);  // R2 low byte keeps high byte: 260
    write(2'b11, 8'hFF); idle(66000);// R2 largest divisor
    write(2'b11, 8'h00); idle(9);    // both halves to zero
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule